// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast peripheral clock into the bit timing of a CAN node. A prescaler divides the clock into time quanta. A segment sequencer then steps each bit through three parts: a one-quantum synchronization segment, a first timing segment (propagation plus phase 1) and a second phase segment. The sequencer marks the sample point and the start of each bit. It keeps the local bit clock aligned to falling edges on the receive line. While the bus is idle it restarts the bit outright. On a busy bus it stretches phase 1 or trims phase 2 by a bounded amount.

Configuration fields are written as the wanted value minus one. A configuration outside the legal ranges raises an error flag, and the counters then stay halted. Frame decoding, stuffing and arbitration are left to the logic that consumes the sample strobe and the sampled bit.

Top module: `can_bit_timer`

## Requirements
- R1: Fields decode as value plus one: quantum length Q = presc_m1+1 clocks, T1 = seg1_m1+1, T2 = seg2_m1+1, J = jump_m1+1. cfg_err is high exactly when any of these fails: 4 ≤ T1 ≤ 16, 2 ≤ T2 ≤ 8, 1 ≤ J ≤ 4, 8 ≤ T1+T2+1 ≤ 25, T1 > T2, T2 ≥ J.
- R2: While en is low or cfg_err is high, the timing is held in reset and neither sample_pulse nor bit_start is asserted. In the first clock where en is high and the configuration is legal, bit_start is asserted.
- R3: With no falling edge on rx, bit_start repeats every Q·(T1+T2+1) clocks.
- R4: bit_start is a one-clock pulse in the first clock of the synchronization segment. sample_pulse is a one-clock pulse in the last clock of the first timing segment, Q·(1+T1)−1 clocks after bit_start.
- R5: rx_bit takes the value of rx in the sample_pulse clock, shows it from the next clock on, and holds it until the next sample point. It resets to 1 (recessive is 1, dominant is 0).
- R6: An edge is a clock where rx is 0 and was 1 in the previous clock. The bus counts as idle after reset and after each enable. An edge on an idle bus is a hard synchronization: bit_start is asserted in the next clock, no jump-width limit applies, and the bus is no longer idle.
- R7: The bus becomes idle again after IDLE_BITS (default 11) consecutive sample points that each see rx at 1. An edge after that is again a hard synchronization.
- R8: On a busy bus, an edge in quantum k (counted from 0) of the first timing segment lengthens that segment by min(k+1, J) quanta, which delays the sample point and the next bit_start by the same amount.
- R9: On a busy bus, an edge in quantum k of the second segment has an early error of e = T2−k quanta. If e ≤ J, the bit ends and bit_start is asserted in the next clock. Otherwise the second segment is shortened by J quanta.
- R10: At most one resynchronization is applied per bit. An edge inside the synchronization segment changes no timing.
- R11: An edge that falls in the sample_pulse clock is sampled but changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable |
| presc_m1 | input | PRESC_W | Clocks per quantum, minus one |
| seg1_m1 | input | SEG1_W | First timing segment in quanta, minus one |
| seg2_m1 | input | SEG2_W | Second phase segment in quanta, minus one |
| jump_m1 | input | JUMP_W | Resynchronization jump width, minus one |
| rx | input | 1 | Receive line, 1 = recessive |
| sample_pulse | output | 1 | Sample point strobe |
| rx_bit | output | 1 | Value of rx at the latest sample point |
| bit_start | output | 1 | First clock of each bit |
| cfg_err | output | 1 | Configuration out of range |

## Verification
The close case is a falling edge on rx that lands in the very clock of the sample point. There, sampling and resynchronization compete for the same cycle. The bench drives a one-clock dominant dip timed to the sample_pulse clock of a known bit. It then checks that rx_bit shows 0, that the sample point stays at its nominal offset, and that the next bit_start keeps the unadjusted period. Neighbouring dips one quantum earlier, in the synchronization segment and in phase 2 show the contrasting adjusted timings, and a randomized sweep of configurations checks the legality rules and the nominal period.

// File: rtl/can_bt_pkg.sv
// Package: shared types and legal ranges for the CAN bit timer.
// Assumes lengths are in time quanta; all limits are inclusive.
package can_bt_pkg;
    typedef enum logic [1:0] {SEG_SYNC, SEG_TS1, SEG_TS2} seg_e;

    localparam int TS1_MIN  = 4;
    localparam int TS1_MAX  = 16;
    localparam int TS2_MIN  = 2;
    localparam int TS2_MAX  = 8;
    localparam int JUMP_MIN = 1;
    localparam int JUMP_MAX = 4;
    localparam int BIT_MIN  = 8;
    localparam int BIT_MAX  = 25;
endpackage

// File: rtl/can_bt_cfg.sv
// Decodes the minus-one configuration fields into lengths and judges
// whether they form a legal bit. Purely combinational.
// Assumes LEN_W can hold TS1_MAX + JUMP_MAX.
module can_bt_cfg
    import can_bt_pkg::*;
#(
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int JUMP_W = 2,
    parameter int LEN_W  = 5
) (
    input  logic [SEG1_W-1:0] seg1_m1,
    input  logic [SEG2_W-1:0] seg2_m1,
    input  logic [JUMP_W-1:0] jump_m1,
    output logic [LEN_W-1:0]  t1_len,
    output logic [LEN_W-1:0]  t2_len,
    output logic [LEN_W-1:0]  jump_len,
    output logic              cfg_ok
);
    int len1, len2, lenj, total;

    // Decode fields and test every range and ordering rule.
    always_comb begin
        len1  = int'(seg1_m1) + 1;
        len2  = int'(seg2_m1) + 1;
        lenj  = int'(jump_m1) + 1;
        total = len1 + len2 + 1;
        cfg_ok = (len1 >= TS1_MIN) && (len1 <= TS1_MAX)
              && (len2 >= TS2_MIN) && (len2 <= TS2_MAX)
              && (lenj >= JUMP_MIN) && (lenj <= JUMP_MAX)
              && (total >= BIT_MIN) && (total <= BIT_MAX)
              && (len1 > len2) && (len2 >= lenj);
        t1_len   = LEN_W'(len1);
        t2_len   = LEN_W'(len2);
        jump_len = LEN_W'(lenj);
    end
endmodule

// File: rtl/can_bt_presc.sv
// Time-quantum prescaler: counts clocks within a quantum.
// Assumes presc_m1 is steady while run is high; restart re-aligns the
// quantum so that the next clock is the first of a new quantum.
module can_bt_presc #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc_m1,
    output logic               tq_last,
    output logic               tq_first
);
    logic [PRESC_W-1:0] cnt;

    // Clock counter inside the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) cnt <= '0;
        else if (cnt == presc_m1)      cnt <= '0;
        else                           cnt <= cnt + PRESC_W'(1);
    end

    assign tq_last  = (cnt == presc_m1);
    assign tq_first = (cnt == '0);
endmodule

// File: rtl/can_bt_seq.sv
// Segment sequencer: walks each bit through sync, first and second
// segments, applies hard sync and resynchronization on falling rx
// edges, tracks bus idle and captures the sampled bit.
// Assumes lengths come from a legal configuration while run is high.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int LEN_W     = 5,
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rx,
    input  logic [LEN_W-1:0] t1_len,
    input  logic [LEN_W-1:0] t2_len,
    input  logic [LEN_W-1:0] jump_len,
    input  logic             tq_last,
    input  logic             tq_first,
    output logic             sample_o,
    output logic             bit_start_o,
    output logic             rx_bit_o,
    output logic             restart_o
);
    localparam int IDLE_W = $clog2(IDLE_BITS + 1);

    seg_e              seg;
    logic [LEN_W-1:0]  q, seg_len, cur_len, late_err, late_adj, early_err;
    logic              resync_done, idle, rx_prev, rx_bit;
    logic [IDLE_W-1:0] idle_cnt;
    logic              fall, sample_cyc, hard, resync_ok, late, early;
    logic              early_end, seg_done;

    // Edge classification and effective segment length this clock.
    always_comb begin
        fall       = rx_prev & ~rx;
        sample_cyc = run && (seg == SEG_TS1) && (q == seg_len - LEN_W'(1)) && tq_last;
        hard       = run && idle && fall;
        resync_ok  = run && !idle && fall && !resync_done;
        late       = resync_ok && (seg == SEG_TS1) && !sample_cyc;
        early      = resync_ok && (seg == SEG_TS2);
        late_err   = q + LEN_W'(1);
        late_adj   = (late_err < jump_len) ? late_err : jump_len;
        early_err  = seg_len - q;
        early_end  = early && (early_err <= jump_len);
        if (late)       cur_len = t1_len + late_adj;
        else if (early) cur_len = t2_len - jump_len;
        else            cur_len = seg_len;
        seg_done   = tq_last && (q == cur_len - LEN_W'(1));
    end

    assign restart_o = hard || early_end;

    // Segment state, quantum index and per-bit resync bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seg <= SEG_SYNC; q <= '0; seg_len <= '0; resync_done <= 1'b0;
        end else if (restart_o) begin
            seg <= SEG_SYNC; q <= '0; resync_done <= 1'b0;
        end else begin
            if (late || early) begin
                seg_len     <= cur_len;
                resync_done <= 1'b1;
            end
            if (tq_last) begin
                case (seg)
                    SEG_SYNC: begin seg <= SEG_TS1; q <= '0; seg_len <= t1_len; end
                    SEG_TS1: begin
                        if (seg_done) begin seg <= SEG_TS2; q <= '0; seg_len <= t2_len; end
                        else q <= q + LEN_W'(1);
                    end
                    SEG_TS2: begin
                        if (seg_done) begin seg <= SEG_SYNC; q <= '0; resync_done <= 1'b0; end
                        else q <= q + LEN_W'(1);
                    end
                    default: seg <= SEG_SYNC;
                endcase
            end
        end
    end

    // Bus-idle tracking from consecutive recessive samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            idle <= 1'b1; idle_cnt <= '0;
        end else if (hard) begin
            idle <= 1'b0; idle_cnt <= '0;
        end else if (sample_cyc) begin
            if (!rx)                                     idle_cnt <= '0;
            else if (idle_cnt == IDLE_W'(IDLE_BITS - 1)) idle <= 1'b1;
            else                                         idle_cnt <= idle_cnt + IDLE_W'(1);
        end
    end

    // Previous rx for edge detection and the held sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev <= 1'b1; rx_bit <= 1'b1;
        end else begin
            rx_prev <= rx;
            if (sample_cyc) rx_bit <= rx;
        end
    end

    assign sample_o    = sample_cyc;
    assign bit_start_o = run && (seg == SEG_SYNC) && tq_first;
    assign rx_bit_o    = rx_bit;

    assert_hard_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> (bit_start_o || !run));
    assert_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        early_end |=> (bit_start_o || !run));
    assert_single_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);
    assert_sample_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !bit_start_o);
    assert_one_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_done && run && !restart_o && seg != SEG_SYNC) |=> $stable(seg_len) || !run || seg != $past(seg));
endmodule

// File: rtl/can_bit_timer.sv
// Top: CAN bit timing generator. Connects configuration check,
// quantum prescaler and segment sequencer.
// Assumes configuration fields change only while en is low.
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int PRESC_W   = 6,
    parameter int SEG1_W    = 4,
    parameter int SEG2_W    = 3,
    parameter int JUMP_W    = 2,
    parameter int IDLE_BITS = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc_m1,
    input  logic [SEG1_W-1:0]  seg1_m1,
    input  logic [SEG2_W-1:0]  seg2_m1,
    input  logic [JUMP_W-1:0]  jump_m1,
    input  logic               rx,
    output logic               sample_pulse,
    output logic               rx_bit,
    output logic               bit_start,
    output logic               cfg_err
);
    localparam int LEN_W = $clog2(TS1_MAX + JUMP_MAX + 1);

    logic [LEN_W-1:0] t1_len, t2_len, jump_len;
    logic             cfg_ok, run, tq_last, tq_first, restart;

    can_bt_cfg #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .JUMP_W(JUMP_W), .LEN_W(LEN_W)) u_cfg (
        .seg1_m1(seg1_m1), .seg2_m1(seg2_m1), .jump_m1(jump_m1),
        .t1_len(t1_len), .t2_len(t2_len), .jump_len(jump_len), .cfg_ok(cfg_ok));

    assign run     = en && cfg_ok;
    assign cfg_err = !cfg_ok;

    can_bt_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .presc_m1(presc_m1), .tq_last(tq_last), .tq_first(tq_first));

    can_bt_seq #(.LEN_W(LEN_W), .IDLE_BITS(IDLE_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .rx(rx),
        .t1_len(t1_len), .t2_len(t2_len), .jump_len(jump_len),
        .tq_last(tq_last), .tq_first(tq_first),
        .sample_o(sample_pulse), .bit_start_o(bit_start),
        .rx_bit_o(rx_bit), .restart_o(restart));

    assert_halt_on_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !(sample_pulse || bit_start));
    assert_rxbit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pulse |=> $stable(rx_bit));
endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
    logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, rx = 1'b1;
    logic [5:0] presc_m1 = 6'd1;
    logic [3:0] seg1_m1 = 4'd5;
    logic [2:0] seg2_m1 = 3'd2;
    logic [1:0] jump_m1 = 2'd1;
    logic       sample_pulse, rx_bit, bit_start, cfg_err;

    int cyc = 0, n_chk = 0, n_fail = 0, e0 = 0;
    int bs_h[512], sp_h[512];
    int bs_n = 0, sp_n = 0;
    bit done = 1'b0;

    can_bit_timer dut (.clk(clk), .rst_n(rst_n), .en(en), .presc_m1(presc_m1),
        .seg1_m1(seg1_m1), .seg2_m1(seg2_m1), .jump_m1(jump_m1), .rx(rx),
        .sample_pulse(sample_pulse), .rx_bit(rx_bit), .bit_start(bit_start),
        .cfg_err(cfg_err));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Event recorder, sampled just after the falling edge.
    always @(negedge clk) begin
        #1;
        if (bit_start && bs_n < 512) begin bs_h[bs_n] = cyc; bs_n++; end
        if (sample_pulse && sp_n < 512) begin sp_h[sp_n] = cyc; sp_n++; end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got cycle %0d expected end before 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(int got, int exp, string req);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int nxt_bs(int from);
        for (int i = 0; i < bs_n; i++) if (bs_h[i] >= from) return bs_h[i];
        return -1;
    endfunction

    function automatic int nxt_sp(int from);
        for (int i = 0; i < sp_n; i++) if (sp_h[i] >= from) return sp_h[i];
        return -1;
    endfunction

    function automatic bit legal(int p1, int p2, int pj);
        int a = p1 + 1, b = p2 + 1, j = pj + 1, t = a + b + 1;
        return a >= 4 && a <= 16 && b >= 2 && b <= 8 && j >= 1 && j <= 4
            && t >= 8 && t <= 25 && a > b && b >= j;
    endfunction

    task automatic go_to(int c);
        do @(negedge clk); while (cyc < c);
    endtask

    task automatic dip(int c);
        go_to(c); rx = 1'b0;
        @(negedge clk); rx = 1'b1;
    endtask

    task automatic restart();
        @(negedge clk); rx = 1'b1; en = 1'b0;
        @(negedge clk); @(negedge clk);
        bs_n = 0; sp_n = 0; en = 1'b1; e0 = cyc;
    endtask

    task automatic hsync(output int h);
        dip(e0 + 5);
        h = e0 + 6;
    endtask

    // Legality check, then nominal timing or halt depending on legality.
    task automatic run_cfg(int p, int a, int b, int j);
        int q, t1, per, sp;
        bit ok;
        @(negedge clk); en = 1'b0; rx = 1'b1;
        presc_m1 = 6'(p); seg1_m1 = 4'(a); seg2_m1 = 3'(b); jump_m1 = 2'(j);
        @(negedge clk);
        ok = legal(a, b, j);
        chk(int'(cfg_err), int'(!ok), "R1 cfg_err");
        q = p + 1; t1 = a + 1; per = q * (a + b + 3); sp = q * (1 + t1) - 1;
        bs_n = 0; sp_n = 0; en = 1'b1; e0 = cyc;
        if (ok) begin
            go_to(e0 + 2 * per + 4);
            chk(nxt_bs(e0), e0, "R2 first bit_start on enable");
            chk(nxt_bs(e0 + 1), e0 + per, "R3 bit period");
            chk(nxt_sp(e0), e0 + sp, "R4 sample offset");
        end else begin
            go_to(e0 + 60);
            chk(bs_n + sp_n, 0, "R2 halted on bad config");
        end
    endtask

    initial begin
        int h, b;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state with en low.
        chk(int'(bit_start), 0, "R2 reset bit_start");
        chk(int'(sample_pulse), 0, "R2 reset sample_pulse");
        chk(int'(rx_bit), 1, "R5 reset rx_bit");
        chk(int'(cfg_err), 0, "R1 legal default");
        bs_n = 0; sp_n = 0;
        repeat (30) @(negedge clk);
        chk(bs_n + sp_n, 0, "R2 no pulses while disabled");

        // Config: Q=2, T1=6, T2=3, J=2 -> period 20, sample at +13.
        restart(); hsync(h);
        go_to(h + 40);
        chk(nxt_bs(e0 + 1), h, "R6 hard sync restarts bit");
        chk(nxt_sp(h), h + 13, "R4 sample after hard sync");
        chk(nxt_bs(h + 1), h + 20, "R3 period after hard sync");
        go_to(h + 14);
        chk(int'(rx_bit), 1, "R5 recessive sampled");

        restart(); hsync(h); b = h + 20;
        dip(b + 2); go_to(b + 30);
        chk(nxt_sp(b), b + 15, "R8 late edge k=0 sample");
        chk(nxt_bs(b + 1), b + 22, "R8 late edge k=0 next bit");

        restart(); hsync(h); b = h + 20;
        dip(b + 8); go_to(b + 30);
        chk(nxt_sp(b), b + 17, "R8 late edge clamped to J");
        chk(nxt_bs(b + 1), b + 24, "R8 clamped next bit");

        restart(); hsync(h); b = h + 20;
        dip(b + 2); dip(b + 6); go_to(b + 30);
        chk(nxt_sp(b), b + 15, "R10 second edge ignored");
        chk(nxt_bs(b + 1), b + 22, "R10 one resync per bit");

        restart(); hsync(h); b = h + 20;
        dip(b); go_to(b + 30);
        chk(nxt_sp(b), b + 13, "R10 sync edge no shift");
        chk(nxt_bs(b + 1), b + 20, "R10 sync edge period");

        restart(); hsync(h); b = h + 20;
        dip(b + 13); go_to(b + 14);
        chk(int'(rx_bit), 0, "R11 dominant sampled at coincident edge");
        go_to(b + 30);
        chk(nxt_sp(b), b + 13, "R11 sample point unchanged");
        chk(nxt_bs(b + 1), b + 20, "R11 no adjustment");
        go_to(b + 34);
        chk(int'(rx_bit), 1, "R5 next sample recessive");

        restart(); hsync(h); b = h + 20;
        dip(b + 18); go_to(b + 30);
        chk(nxt_bs(b + 1), b + 19, "R9 early edge ends bit");

        restart(); hsync(h); b = h + 20;
        dip(b + 14); go_to(b + 30);
        chk(nxt_bs(b + 1), b + 16, "R9 early edge shortens by J");

        restart(); hsync(h); b = h + 240;
        dip(b + 8); go_to(b + 20);
        chk(nxt_bs(b + 1), b + 9, "R7 idle again gives hard sync");

        // Boundary configurations.
        run_cfg(0, 2, 1, 0);
        run_cfg(0, 7, 0, 0);
        run_cfg(1, 3, 3, 0);
        run_cfg(0, 7, 1, 2);
        run_cfg(0, 3, 1, 0);
        run_cfg(0, 4, 1, 1);
        run_cfg(3, 15, 7, 3);
        // Random sweep.
        for (int i = 0; i < 30; i++)
            run_cfg($urandom_range(0, 3), $urandom_range(0, 15),
                    $urandom_range(0, 7), $urandom_range(0, 3));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule